// File: doc/BRIEF.md
# External Interrupt Pulse Qualifier

This block watches one external interrupt line on the processor clock and decides which transitions count as real interrupt events. The line reaches the block already corrected for polarity, so the only active event is a low-to-high change. The line passes through a synchroniser before any decision is made. An event is accepted only when the synchronised line has been low for at least `LOW_MIN` consecutive cycles and then high for at least `HIGH_MIN` consecutive cycles. Short glitches in either phase are dropped.

Once the pattern completes, the block records the event in a latch flop. One cycle later it emits a single-cycle recognised pulse, which drives the flag-set input of the interrupt dispatch logic. Reset starts the block as if the line had been high. A line that is already high when reset is released therefore raises nothing until it has gone through a proper low phase.

Top module: `irq_pulse_qualifier`

## Requirements
- R1: After reset, `irqRecognised` is 0, and a line held high from reset onward never produces a pulse.
- R2: With default parameters, let edge k be the clock edge that samples the second consecutive high input, after at least two consecutive low samples. `irqRecognised` is then 1 during exactly the cycle that follows edge k+3: two synchroniser stages, one latch stage and one recognise stage.
- R3: A low phase shorter than `LOW_MIN` samples, for example a one-cycle dip, does not arm the qualifier, and no pulse follows the next high phase.
- R4: A high phase shorter than `HIGH_MIN` samples after a valid low phase produces no pulse.
- R5: Each qualified event gives a pulse exactly one cycle wide. Keeping the line high afterwards gives no further pulses until a new qualifying low phase occurs.
- R6: A high-to-low transition never produces a pulse.
- R7: The recognised pulse follows the internal latched indication by exactly one cycle.
- R8: Low phases of any length of at least `LOW_MIN` qualify. Back-to-back minimum patterns (low, low, high, high, repeated) produce one pulse per repetition, every four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; every stage samples on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rawIn | input | 1 | Polarity-corrected external interrupt line, asynchronous to `clk` |
| irqRecognised | output | 1 | One-cycle pulse per qualified event, to the flag-set input |

## Verification
The bench targets one-cycle dips inside a high phase. A qualifier that does not count the low run would turn each of these into a spurious interrupt. It also targets one-cycle high spikes after a long low phase, which a plain edge detector would report. Long high holds after an accepted event expose a design that pulses on every high cycle instead of once per event. Back-to-back minimum patterns and an exact four-edge latency check catch an off-by-one in the synchroniser depth, the run counter or the latch-to-recognise delay.

// File: rtl/irq_qual_pkg.sv
package irq_qual_pkg;

  typedef enum logic [1:0] {
    ST_HIGH = 2'd0,
    ST_LOW  = 2'd1,
    ST_RISE = 2'd2
  } qualState_t;

  typedef struct packed {
    logic runStart;
    logic runStep;
    logic latchEvt;
  } qualStrobes_t;

endpackage

// File: rtl/irq_qual_datapath.sv
module irq_qual_datapath
  import irq_qual_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 2,
  parameter int CNT_CAP     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  qualStrobes_t     strobes,
  output logic             pinSync,
  output logic [CNT_W-1:0] runCnt,
  output logic             irqRecognised
);

  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CNT_CAP);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   latchQ;
  logic                   recogQ;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= rawIn;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      end
    end
  endgenerate

  assign pinSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (strobes.runStart) begin
      runCnt <= CNT_W'(1);
    end else if (strobes.runStep && (runCnt < CAP_V)) begin
      runCnt <= runCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= 1'b0;
      recogQ <= 1'b0;
    end else begin
      latchQ <= strobes.latchEvt;
      recogQ <= latchQ;
    end
  end

  assign irqRecognised = recogQ;

  AST_RECOG_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    latchQ |=> recogQ); // R7

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    recogQ |=> !recogQ); // R5

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= CAP_V); // R8

endmodule

// File: rtl/irq_qual_control.sv
module irq_qual_control
  import irq_qual_pkg::*;
#(
  parameter int LOW_MIN  = 2,
  parameter int HIGH_MIN = 2,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinSync,
  input  logic [CNT_W-1:0] runCnt,
  output qualStrobes_t     strobes
);

  localparam logic [CNT_W-1:0] LOW_V     = CNT_W'(LOW_MIN);
  localparam logic [CNT_W-1:0] HIGH_M1_V = CNT_W'(HIGH_MIN - 1);

  qualState_t stateQ;
  qualState_t stateD;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_HIGH: begin
        if (!pinSync) begin
          stateD           = ST_LOW;
          strobes.runStart = 1'b1;
        end
      end
      ST_LOW: begin
        if (!pinSync) begin
          strobes.runStep = 1'b1;
        end else if (runCnt >= LOW_V) begin
          if (HIGH_MIN <= 1) begin
            strobes.latchEvt = 1'b1;
            stateD           = ST_HIGH;
          end else begin
            strobes.runStart = 1'b1;
            stateD           = ST_RISE;
          end
        end else begin
          stateD = ST_HIGH;
        end
      end
      ST_RISE: begin
        if (!pinSync) begin
          strobes.runStart = 1'b1;
          stateD           = ST_LOW;
        end else if (runCnt >= HIGH_M1_V) begin
          strobes.latchEvt = 1'b1;
          stateD           = ST_HIGH;
        end else begin
          strobes.runStep = 1'b1;
        end
      end
      default: stateD = ST_HIGH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_HIGH;
    else       stateQ <= stateD;
  end

  AST_LATCH_ON_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchEvt |-> pinSync); // R6

  AST_HIGH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchEvt && (HIGH_MIN > 1)) |-> $past(pinSync)); // R4

  AST_NO_LATCH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HIGH) |-> !strobes.latchEvt); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.runStart, strobes.runStep, strobes.latchEvt})); // R8

endmodule

// File: rtl/irq_pulse_qualifier.sv
module irq_pulse_qualifier
  import irq_qual_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_MIN     = 2,
  parameter int HIGH_MIN    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic irqRecognised
);

  localparam int CNT_CAP = (LOW_MIN > HIGH_MIN) ? LOW_MIN : HIGH_MIN;
  localparam int CNT_W   = $clog2(CNT_CAP + 1);

  qualStrobes_t     strobes;
  logic             pinSync;
  logic [CNT_W-1:0] runCnt;

  irq_qual_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W),
    .CNT_CAP    (CNT_CAP)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .rawIn        (rawIn),
    .strobes      (strobes),
    .pinSync      (pinSync),
    .runCnt       (runCnt),
    .irqRecognised(irqRecognised)
  );

  irq_qual_control #(
    .LOW_MIN (LOW_MIN),
    .HIGH_MIN(HIGH_MIN),
    .CNT_W   (CNT_W)
  ) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .pinSync(pinSync),
    .runCnt (runCnt),
    .strobes(strobes)
  );

endmodule

// File: tb/tb_irq_pulse_qualifier.sv
module tb_irq_pulse_qualifier;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawIn = 1'b1;
  logic irqRecognised;

  int vectors = 0;
  int miscompares = 0;
  logic [6:0] hist = '1;

  irq_pulse_qualifier dut (
    .clk          (clk),
    .rstN         (rstN),
    .rawIn        (rawIn),
    .irqRecognised(irqRecognised)
  );

  always #2 clk = ~clk;

  function automatic logic expectPulse(input logic [6:0] h);
    return h[3] & h[4] & ~h[5] & ~h[6];
  endfunction

  task automatic check(input string tag, input logic exp);
    vectors++;
    if (irqRecognised !== exp) begin
      miscompares++;
      $display("FAIL %s at vector %0d: irqRecognised=%b expected=%b", tag, vectors, irqRecognised, exp);
    end
  endtask

  task automatic step(input logic v, input string tag);
    logic e;
    rawIn = v;
    @(posedge clk);
    hist = {hist[5:0], v};
    @(negedge clk);
    e = expectPulse(hist);
    check(e ? "R2" : tag, e);
  endtask

  task automatic run(input logic v, input int n, input string tag);
    for (int i = 0; i < n; i++) step(v, tag);
  endtask

  task automatic flush(input string tag);
    run(1'b1, 8, tag);
  endtask

  initial begin
    #2000000;
    miscompares++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic cur;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 1'b0);
    rstN = 1'b1;
    run(1'b1, 12, "R1");
    run(1'b0, 1, "R3");
    run(1'b1, 8, "R3");
    run(1'b0, 6, "R4");
    run(1'b1, 1, "R4");
    run(1'b0, 3, "R4");
    flush("R4");
    run(1'b0, 2, "R2");
    run(1'b1, 12, "R5");
    run(1'b0, 1, "R6");
    run(1'b0, 9, "R6");
    run(1'b1, 10, "R7");
    for (int k = 0; k < 6; k++) begin
      run(1'b0, 2, "R8");
      run(1'b1, 2, "R8");
    end
    run(1'b0, 20, "R8");
    flush("R8");
    cur = 1'b0;
    for (int k = 0; k < 700; k++) begin
      run(cur, 1 + int'($urandom_range(3)), "R3");
      cur = ~cur;
    end
    flush("R5");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule